// File: doc/BRIEF.md
# Periodic InfoFrame Packet Scheduler

This block decides which auxiliary packet type goes into the next free blanking slot of a video transmitter. Every packet type has four controls: an enable, a send-now pulse, a once/repeat selector, and a spacing in frames. A type in once mode is sent a single time after its send-now pulse. A type in repeat mode is sent once every N frames. The frame is marked by the leading edge of vsync.

One type, the metadata burst type, works differently. It has no frame spacing. In repeat mode it is sent a programmed number of times inside each frame.

The packet inserter grants a slot while this block holds its request. In that grant cycle the block serves the packet type shown on its index output. When several types are waiting, the lowest type index wins. A waiting repeat packet is held until it is served, so it is not lost when the next vsync arrives. Building the packet contents, checksums and line coding are done elsewhere.

Top module: `ifs_sched`

## Requirements
- R1: A type whose enable bit is 0 is never requested. A send-now pulse that arrives while the type is disabled is dropped. Clearing the enable bit also discards a repeat packet that was waiting.
- R2: In once mode (repeat bit 0), a send-now pulse sets that type's trigger bit, shown on `now_pend[i]`, and the type is requested. The trigger bit clears by itself in the cycle after the type is granted.
- R3: In repeat mode (repeat bit 1), a send-now pulse has no effect: `now_pend[i]` stays 0.
- R4: In repeat mode with spacing S (4 bits per type, type i at `spacing[4i+3:4i]`), the first vsync leading edge after the mode is entered raises a packet. After that, a packet is raised on every S-th leading edge.
- R5: A spacing of 0 behaves like a spacing of 1, so a packet is raised on every vsync leading edge.
- R6: When several types are eligible, `pkt_idx` shows the lowest eligible index. Each grant serves exactly one packet, of that type.
- R7: A repeat packet that is still waiting at a later vsync leading edge is kept. It is still one packet, so a single grant clears it.
- R8: The burst type (index NUM_TYPES-1) in repeat mode is loaded with `gm_count` copies on each vsync leading edge. Each grant removes one copy. A count of 0 sends nothing. Copies left over at the next leading edge are replaced by the new count.
- R9: `pkt_req` is 1 exactly while some type is eligible. Without `slot_grant`, nothing is consumed: the request and the trigger bits hold.
- R10: After reset, `pkt_req` is 0 and all trigger bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| vsync | input | 1 | Vertical sync; the leading edge marks a frame |
| slot_grant | input | 1 | Blanking slot granted by the packet inserter |
| type_en | input | NUM_TYPES | Per-type enable |
| type_rpt | input | NUM_TYPES | Per-type mode: 0 once, 1 repeat |
| now_set | input | NUM_TYPES | Per-type send-now pulse |
| spacing | input | NUM_TYPES*SPACE_W | Per-type frame spacing; type i at bits [4i+3:4i] |
| gm_count | input | CNT_W | Copies per frame for the burst type |
| pkt_req | output | 1 | A packet is waiting for a slot |
| pkt_idx | output | IDX_W | Index of the packet type to send |
| now_pend | output | NUM_TYPES | Per-type send-now trigger state |

## Verification
The hardest situation to reach is a repeat packet that is still waiting when the next vsync edge arrives. In the same scenario, burst copies must survive from one frame into the next. The stimulus reaches both by issuing vsync pulses with the grant deliberately held off. It then counts the grants needed to empty the request, which must be exactly one for a repeat packet and exactly the new count for the burst type. The spacing rule is covered by a table that holds one spacing value per entry. For each entry the bench resets the type's frame counter by leaving repeat mode, then counts the packets raised over twelve frames.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
  // Frames between repeated sends; a spacing of 0 means every frame.
  function automatic int unsigned frame_period(input int unsigned field);
    return (field == 0) ? 1 : field;
  endfunction
endpackage

// File: rtl/ifs_slot.sv
module ifs_slot #(
  parameter int unsigned CNT_W    = 8,
  parameter bit          IS_BURST = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vs_edge,
  input  logic             en,
  input  logic             rpt,
  input  logic             now_set,
  input  logic [CNT_W-1:0] reload,
  input  logic             served,
  output logic             eligible,
  output logic             trig
);
  logic trig_q;
  logic rep_on;
  logic rep_elig;

  assign rep_on = en & rpt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            trig_q <= 1'b0;
    else if (!en || rpt)   trig_q <= 1'b0;
    else if (now_set)      trig_q <= 1'b1;
    else if (served)       trig_q <= 1'b0;
  end

  generate
    if (IS_BURST) begin : g_burst
      logic [CNT_W-1:0] burst_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          burst_q <= '0;
        else if (!rep_on)                    burst_q <= '0;
        else if (vs_edge)                    burst_q <= reload;
        else if (served && burst_q != '0)    burst_q <= burst_q - 1'b1;
      end
      assign rep_elig = (burst_q != '0);

      p_burst_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_on && served && !vs_edge && burst_q != '0) |=> (burst_q == $past(burst_q) - 1'b1));
    end else begin : g_frame
      logic [CNT_W-1:0] cnt_q;
      logic             pend_q;
      logic             raise;
      assign raise = rep_on & vs_edge & (cnt_q <= 1);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q  <= '0;
          pend_q <= 1'b0;
        end else if (!rep_on) begin
          cnt_q  <= '0;
          pend_q <= 1'b0;
        end else begin
          if (vs_edge)
            cnt_q <= (cnt_q <= 1) ? CNT_W'(ifs_pkg::frame_period(int'(reload))) : cnt_q - 1'b1;
          pend_q <= raise | (pend_q & ~served);
        end
      end
      assign rep_elig = pend_q;

      p_pend_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_on && pend_q && !served) |=> pend_q);
      p_raise_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(vs_edge));
    end
  endgenerate

  assign eligible = en & (rpt ? rep_elig : trig_q);
  assign trig     = trig_q;

  p_trig_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (served && en && !rpt && !now_set) |=> !trig_q);
  p_now_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rpt |=> !trig_q);
endmodule

// File: rtl/ifs_arbiter.sv
module ifs_arbiter #(
  parameter int unsigned NUM_TYPES = 11,
  parameter int unsigned IDX_W     = (NUM_TYPES > 1) ? $clog2(NUM_TYPES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_TYPES-1:0] elig,
  output logic                 req,
  output logic [IDX_W-1:0]     idx
);
  function automatic logic [IDX_W-1:0] lowest_set(input logic [NUM_TYPES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_TYPES - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  assign req = |elig;
  assign idx = lowest_set(elig);

  p_req_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> elig[idx]);
endmodule

// File: rtl/ifs_sched.sv
module ifs_sched #(
  parameter int unsigned NUM_TYPES = 11,
  parameter int unsigned SPACE_W   = 4,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned IDX_W     = (NUM_TYPES > 1) ? $clog2(NUM_TYPES) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         vsync,
  input  logic                         slot_grant,
  input  logic [NUM_TYPES-1:0]         type_en,
  input  logic [NUM_TYPES-1:0]         type_rpt,
  input  logic [NUM_TYPES-1:0]         now_set,
  input  logic [NUM_TYPES*SPACE_W-1:0] spacing,
  input  logic [CNT_W-1:0]             gm_count,
  output logic                         pkt_req,
  output logic [IDX_W-1:0]             pkt_idx,
  output logic [NUM_TYPES-1:0]         now_pend
);
  localparam int unsigned BURST_IDX = NUM_TYPES - 1;

  logic                 vs_d;
  logic                 vs_edge;
  logic [NUM_TYPES-1:0] elig;
  logic [NUM_TYPES-1:0] served;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vs_d <= 1'b0;
    else        vs_d <= vsync;
  end
  assign vs_edge = vsync & ~vs_d;

  for (genvar i = 0; i < NUM_TYPES; i++) begin : g_type
    localparam bit BURST = (i == BURST_IDX);
    logic [CNT_W-1:0] reload;
    if (BURST) begin : g_rl_burst
      assign reload = gm_count;
    end else begin : g_rl_frame
      assign reload = CNT_W'(spacing[i*SPACE_W +: SPACE_W]);
    end
    assign served[i] = slot_grant & pkt_req & (pkt_idx == IDX_W'(i));
    ifs_slot #(.CNT_W(CNT_W), .IS_BURST(BURST)) u_slot (
      .clk(clk), .rst_n(rst_n), .vs_edge(vs_edge),
      .en(type_en[i]), .rpt(type_rpt[i]), .now_set(now_set[i]),
      .reload(reload), .served(served[i]),
      .eligible(elig[i]), .trig(now_pend[i])
    );
  end

  ifs_arbiter #(.NUM_TYPES(NUM_TYPES), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .elig(elig), .req(pkt_req), .idx(pkt_idx)
  );

  p_grant_enabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_req |-> type_en[pkt_idx]);
  p_one_served_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(served));
endmodule

// File: tb/sim_ifs_sched.sv
module sim_ifs_sched;
  localparam int N = 11;
  localparam int GM = N - 1;

  logic clk = 0, rst_n = 0, vsync = 0, slot_grant = 0;
  logic [N-1:0] type_en = '0, type_rpt = '0, now_set = '0;
  logic [N*4-1:0] spacing = '0;
  logic [7:0] gm_count = '0;
  logic pkt_req;
  logic [3:0] pkt_idx;
  logic [N-1:0] now_pend;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ifs_sched u0 (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .slot_grant(slot_grant),
    .type_en(type_en), .type_rpt(type_rpt), .now_set(now_set),
    .spacing(spacing), .gm_count(gm_count),
    .pkt_req(pkt_req), .pkt_idx(pkt_idx), .now_pend(now_pend)
  );

  // spacing value, expected packets over 12 frames
  localparam logic [11:0] TBL [8] = '{
    {4'd0, 8'd12}, {4'd1, 8'd12}, {4'd2, 8'd6}, {4'd3, 8'd4},
    {4'd4, 8'd3},  {4'd5, 8'd3},  {4'd7, 8'd2}, {4'd15, 8'd1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
    #1;
  endtask

  task automatic vs_pulse;
    @(negedge clk) vsync = 1;
    @(negedge clk) vsync = 0;
    #1;
  endtask

  task automatic grant;
    @(negedge clk) slot_grant = 1;
    @(negedge clk) slot_grant = 0;
    #1;
  endtask

  task automatic pulse_now(input logic [N-1:0] m);
    @(negedge clk) now_set = m;
    @(negedge clk) now_set = '0;
    #1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cnt;
    idle(3);
    chk("R10 req after reset", pkt_req, 0);
    chk("R10 triggers after reset", now_pend, 0);
    rst_n = 1;
    idle(2);

    // R4 / R5: spacing table on type 3
    foreach (TBL[e]) begin
      @(negedge clk) begin
        spacing[12 +: 4] = TBL[e][11:8];
        type_en[3] = 1; type_rpt[3] = 0;
      end
      @(negedge clk) type_rpt[3] = 1;
      #1;
      cnt = 0;
      for (int f = 0; f < 12; f++) begin
        vs_pulse();
        if (pkt_req && pkt_idx == 3) begin
          cnt++;
          grant();
        end
      end
      chk($sformatf("R4 R5 spacing %0d packets", TBL[e][11:8]), cnt, int'(TBL[e][7:0]));
    end
    @(negedge clk) begin type_en = '0; type_rpt = '0; spacing = '0; end
    idle(1);

    // R2 once mode trigger
    @(negedge clk) type_en[5] = 1;
    pulse_now(N'(1) << 5);
    chk("R2 trigger set", now_pend[5], 1);
    chk("R2 request", pkt_req, 1);
    chk("R2 index", pkt_idx, 5);
    idle(4);
    chk("R9 held without grant", now_pend[5], 1);
    chk("R9 req held without grant", pkt_req, 1);
    grant();
    chk("R2 trigger self-cleared", now_pend[5], 0);
    chk("R2 request gone", pkt_req, 0);

    // R3 send-now ignored in repeat mode
    @(negedge clk) type_rpt[5] = 1;
    pulse_now(N'(1) << 5);
    chk("R3 trigger ignored", now_pend[5], 0);
    chk("R3 no request", pkt_req, 0);
    @(negedge clk) begin type_en = '0; type_rpt = '0; end

    // R1 disabled
    pulse_now(N'(1) << 6);
    chk("R1 disabled trigger dropped", now_pend[6], 0);
    chk("R1 disabled no request", pkt_req, 0);
    @(negedge clk) begin type_en[2] = 1; type_rpt[2] = 1; end
    vs_pulse();
    chk("R1 repeat pending idx", pkt_idx, 2);
    @(negedge clk) type_en[2] = 0;
    idle(1);
    chk("R1 disable drops request", pkt_req, 0);
    @(negedge clk) type_en[2] = 1;
    idle(1);
    chk("R1 pending discarded", pkt_req, 0);
    @(negedge clk) begin type_en = '0; type_rpt = '0; end

    // R6 priority
    @(negedge clk) type_en = (N'(1) << 4) | (N'(1) << 7) | (N'(1) << 8);
    pulse_now((N'(1) << 4) | (N'(1) << 7) | (N'(1) << 8));
    chk("R6 first idx", pkt_idx, 4);
    grant();
    chk("R6 one served", now_pend[8:7], 2'b11);
    chk("R6 second idx", pkt_idx, 7);
    grant();
    chk("R6 third idx", pkt_idx, 8);
    grant();
    chk("R6 all served", pkt_req, 0);
    @(negedge clk) type_en = '0;

    // R7 pending kept across vsync
    @(negedge clk) begin type_en[1] = 1; type_rpt[1] = 1; end
    vs_pulse();
    vs_pulse();
    chk("R7 pending kept", pkt_req, 1);
    chk("R7 index", pkt_idx, 1);
    grant();
    chk("R7 single packet", pkt_req, 0);
    @(negedge clk) begin type_en = '0; type_rpt = '0; end

    // R8 burst type
    @(negedge clk) begin type_en[GM] = 1; type_rpt[GM] = 1; gm_count = 3; end
    vs_pulse();
    cnt = 0;
    for (int k = 0; k < 10 && pkt_req; k++) begin
      chk("R8 burst index", pkt_idx, GM);
      cnt++;
      grant();
    end
    chk("R8 copies per frame", cnt, 3);
    @(negedge clk) gm_count = 0;
    vs_pulse();
    chk("R8 zero count", pkt_req, 0);
    @(negedge clk) gm_count = 2;
    vs_pulse();
    grant();
    vs_pulse();
    cnt = 0;
    for (int k = 0; k < 10 && pkt_req; k++) begin
      cnt++;
      grant();
    end
    chk("R8 leftover replaced", cnt, 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule